// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit multiplies two operands of `DATA_W` bits and leaves the double-width result in a pair of result registers. The upper half of the result goes to HI and the lower half goes to LO. The product can also be added to, or subtracted from, the value already held in HI:LO. Each of these three modes comes in a signed form and an unsigned form. The two forms differ only in how the operands are widened: signed operands are sign-extended and unsigned operands are zero-extended.

The multiplier is sequential. A radix-2 shift-add engine handles one multiplier bit per clock. After an operation is accepted, `busy_o` stays high for `DATA_W` cycles. `done_o` then pulses for one cycle, and HI and LO take the new value in that same cycle. While the unit is idle, software-visible moves can load HI or LO directly through separate write ports. Either half can be written alone.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset, HI and LO read zero and `busy_o` and `done_o` are low.
- R2: HI holds bits [2*DATA_W-1:DATA_W] of the double-width result and LO holds bits [DATA_W-1:0].
- R3: Op code 0 (signed multiply) writes the product of the two sign-extended operands to HI:LO.
- R4: Op code 1 (unsigned multiply) writes the product of the two zero-extended operands to HI:LO.
- R5: Op codes 2 (signed) and 3 (unsigned) add the extended product to HI:LO. The sum wraps modulo 2^(2*DATA_W).
- R6: Op codes 4 (signed) and 5 (unsigned) subtract the extended product from HI:LO. The difference wraps modulo 2^(2*DATA_W).
- R7: A start with op code 6 or 7 is ignored. `busy_o` stays low and HI and LO keep their values.
- R8: After a start is accepted at a clock edge, `busy_o` is high for the next `DATA_W` cycles. `done_o` is then high for exactly one cycle with `busy_o` low, and HI and LO show the new result in that same cycle.
- R9: A start that arrives while `busy_o` is high is ignored. The operation in flight keeps its result and its timing.
- R10: While the unit is idle, `hi_we_i` loads `hi_wdata_i` into HI and `lo_we_i` loads `lo_wdata_i` into LO. Each load is visible after the next clock edge and leaves the other half unchanged.
- R11: Direct writes presented while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for an operation |
| op_i | input | 3 | Operation code (0..5 valid) |
| a_i | input | DATA_W | Multiplicand |
| b_i | input | DATA_W | Multiplier |
| hi_we_i | input | 1 | Direct write enable for HI |
| hi_wdata_i | input | DATA_W | Direct write data for HI |
| lo_we_i | input | 1 | Direct write enable for LO |
| lo_wdata_i | input | DATA_W | Direct write data for LO |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | DATA_W | HI read port |
| lo_o | output | DATA_W | LO read port |

## Verification
The bench builds the unit with the default `DATA_W` of 32, so each run takes the full 32-step sequence. This width reaches the extreme operands: the most negative value squared, all-ones unsigned squared, and 64-bit wrap on accumulate and subtract from all-ones and from zero. The last shift-add step has a negative weight in signed mode, so signed operands with the top bit set exercise that step directly. Random operation codes, including the ignored ones, are mixed with direct writes so that accumulation starts from many different HI:LO values.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;

  // op[2:1]: 00 multiply, 01 add, 10 subtract; op[0]: unsigned
  function automatic logic op_valid(input logic [2:0] op);
    return op < 3'd6;
  endfunction

  function automatic acc_mode_e op_mode(input logic [2:0] op);
    case (op[2:1])
      2'b01:   return ACC_ADD;
      2'b10:   return ACC_SUB;
      default: return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hilo_mac_engine.sv
module hilo_mac_engine #(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  signed_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  output logic                  busy_o,
  output logic                  last_o,
  output logic                  done_o,
  output logic [2*DATA_W-1:0]   prod_o
);
  localparam int PW    = 2 * DATA_W;
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic              busy_q, done_q, sgn_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PW-1:0]     mcand_q, acc_q, addend, acc_nxt;
  logic [DATA_W-1:0] mplier_q;
  logic              last;

  assign last   = busy_q && (cnt_q == LAST_CNT);
  assign addend = mplier_q[0] ? mcand_q : '0;
  // top multiplier bit carries negative weight in signed mode
  assign acc_nxt = (sgn_q && cnt_q == LAST_CNT) ? acc_q - addend : acc_q + addend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sgn_q    <= 1'b0;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q   <= 1'b1;
          cnt_q    <= '0;
          sgn_q    <= signed_i;
          mcand_q  <= signed_i ? {{DATA_W{a_i[DATA_W-1]}}, a_i} : {{DATA_W{1'b0}}, a_i};
          mplier_q <= b_i;
          acc_q    <= '0;
        end
      end else begin
        acc_q    <= acc_nxt;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = last;
  assign done_o = done_q;
  assign prod_o = acc_nxt;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> busy_q); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && req_i && !last |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R9
endmodule

// File: rtl/hilo_mac_regs.sv
module hilo_mac_regs
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                load_i,
  input  acc_mode_e           mode_i,
  input  logic [2*DATA_W-1:0] prod_i,
  input  logic                hi_we_i,
  input  logic [DATA_W-1:0]   hi_wdata_i,
  input  logic                lo_we_i,
  input  logic [DATA_W-1:0]   lo_wdata_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o
);
  logic [DATA_W-1:0]   hi_q, lo_q;
  logic [2*DATA_W-1:0] base, result;

  assign base   = (mode_i == ACC_NONE) ? '0 : {hi_q, lo_q};
  assign result = (mode_i == ACC_SUB) ? base - prod_i : base + prod_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      {hi_q, lo_q} <= result;
    end else if (!busy_i) begin
      if (hi_we_i) hi_q <= hi_wdata_i;
      if (lo_we_i) lo_q <= lo_wdata_i;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !load_i |=> $stable(hi_q) && $stable(lo_q)); // R11
  AST_LO_KEEPS_ON_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !load_i && !lo_we_i |=> $stable(lo_q)); // R10
endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              hi_we_i,
  input  logic [DATA_W-1:0] hi_wdata_i,
  input  logic              lo_we_i,
  input  logic [DATA_W-1:0] lo_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  logic                req, busy, last;
  logic [2*DATA_W-1:0] prod;
  acc_mode_e           mode_q;

  assign req = start_i && op_valid(op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= ACC_NONE;
    else if (req && !busy) mode_q <= op_mode(op_i);
  end

  hilo_mac_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .signed_i (!op_i[0]),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done_o),
    .prod_o   (prod)
  );

  hilo_mac_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .load_i     (last),
    .mode_i     (mode_q),
    .prod_i     (prod),
    .hi_we_i    (hi_we_i),
    .hi_wdata_i (hi_wdata_i),
    .lo_we_i    (lo_we_i),
    .lo_wdata_i (lo_wdata_i),
    .hi_o       (hi_o),
    .lo_o       (lo_o)
  );

  assign busy_o = busy;

  AST_BAD_OP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy && !op_valid(op_i) |=> !busy_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
endmodule

// File: tb/hilo_mac_unit_tb_top.sv
module hilo_mac_unit_tb_top;
  localparam int DW = 32;
  localparam realtime HALF = 2.5ns;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0, hi_we_i = 1'b0, lo_we_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [DW-1:0] a_i = '0, b_i = '0, hi_wdata_i = '0, lo_wdata_i = '0;
  logic          busy_o, done_o;
  logic [DW-1:0] hi_o, lo_o;

  int errors = 0, checks = 0;
  logic [2*DW-1:0] model = '0;

  always #(HALF) clk_i = ~clk_i;

  hilo_mac_unit #(.DATA_W(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] expect_val(input logic [2:0] op, input logic [DW-1:0] a,
                                                 input logic [DW-1:0] b, input logic [2*DW-1:0] old);
    logic [2*DW-1:0] ea, eb, p;
    ea = op[0] ? {{DW{1'b0}}, a} : {{DW{a[DW-1]}}, a};
    eb = op[0] ? {{DW{1'b0}}, b} : {{DW{b[DW-1]}}, b};
    p  = ea * eb;
    case (op[2:1])
      2'b01:   return old + p;
      2'b10:   return old - p;
      default: return p;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op[2:1])
      2'b00:   return op[0] ? "R4" : "R3";
      2'b01:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // disturb: inject a start and direct writes mid-operation
  task automatic run_op(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input bit disturb);
    logic [2*DW-1:0] exp;
    exp = expect_val(op, a, b, model);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8 busy after start", {63'd0, busy_o}, 64'd1);
    for (int i = 1; i < DW; i++) begin
      if (disturb && i == 5) begin
        start_i = 1'b1; op_i = 3'd1; a_i = 32'h1234_5678; b_i = 32'h9ABC_DEF0;
        hi_we_i = 1'b1; lo_we_i = 1'b1; hi_wdata_i = 32'hDEAD_BEEF; lo_wdata_i = 32'hCAFE_F00D;
      end
      @(negedge clk_i);
      start_i = 1'b0; hi_we_i = 1'b0; lo_we_i = 1'b0;
      if (disturb && i == 6)
        chk("R11 HI:LO held while busy", {hi_o, lo_o}, model);
    end
    chk("R8 busy high last cycle", {62'd0, busy_o, done_o}, 64'd2);
    @(negedge clk_i);
    chk("R8 done pulse, busy low", {62'd0, busy_o, done_o}, 64'd1);
    chk(disturb ? "R9 result after ignored start" : tag(op), {hi_o, lo_o}, exp);
    chk("R2 HI upper half", {32'd0, hi_o}, {32'd0, exp[2*DW-1:DW]});
    model = exp;
    @(negedge clk_i);
    chk("R8 done single cycle", {63'd0, done_o}, 64'd0);
  endtask

  task automatic wr(input bit whi, input bit wlo, input logic [DW-1:0] hv, input logic [DW-1:0] lv);
    @(negedge clk_i);
    hi_we_i = whi; lo_we_i = wlo; hi_wdata_i = hv; lo_wdata_i = lv;
    @(negedge clk_i);
    hi_we_i = 1'b0; lo_we_i = 1'b0;
    if (whi) model[2*DW-1:DW] = hv;
    if (wlo) model[DW-1:0] = lv;
    chk("R10 direct write", {hi_o, lo_o}, model);
  endtask

  task automatic bad_op(input logic [2:0] op);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = 32'h7; b_i = 32'h9;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7 illegal op no busy", {63'd0, busy_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    chk("R7 illegal op HI:LO kept", {hi_o, lo_o}, model);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 reset HI:LO", {hi_o, lo_o}, 64'd0);
    chk("R1 reset busy/done", {62'd0, busy_o, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", {62'd0, busy_o, done_o}, 64'd0);

    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0);   // R3: 2^62
    chk("R3 min*min", {hi_o, lo_o}, 64'h4000_0000_0000_0000);
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R4
    chk("R4 max*max", {hi_o, lo_o}, 64'hFFFF_FFFE_0000_0001);
    run_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R3: -1
    wr(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(3'd3, 32'h1, 32'h1, 0);                   // R5 wrap to 0
    chk("R5 wrap", {hi_o, lo_o}, 64'd0);
    run_op(3'd5, 32'h1, 32'h1, 0);                   // R6 wrap below 0
    chk("R6 wrap", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op(3'd4, 32'hFFFF_FFFF, 32'h2, 0);           // R6 minus negative
    run_op(3'd2, 32'h8000_0000, 32'h7FFF_FFFF, 0);   // R5 signed
    wr(1, 0, 32'h0123_4567, 32'h0);
    wr(0, 1, 32'h0, 32'h89AB_CDEF);
    bad_op(3'd6);
    bad_op(3'd7);
    run_op(3'd2, 32'h0000_1000, 32'h0000_2000, 1);   // R9 and R11

    for (int n = 0; n < 60; n++) begin
      int sel;
      sel = $urandom % 10;
      if (sel == 0) wr(1, 1, $urandom, $urandom);
      else if (sel == 1) bad_op(3'd6 + 3'($urandom % 2));
      else run_op(3'($urandom % 6), $urandom, $urandom, ($urandom % 8) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule